// File: doc/BRIEF.md
# Third-Order Nine-Level Delta-Sigma Modulator

This block turns a 20-bit unsigned fractional tuning word into a stream of small integer codes, each between 0 and 8. Over time the codes average to the input word scaled by 2^-17. A fractional divider or an oscillator step input consumes one code per modulator step. Inside, three integrators are cascaded. Each integrator is fed back from the quantised code through fixed power-of-two weights. The inter-stage scaling and the quantiser gain use shifts and adds only, so the block has no multiplier.

Both ends of the block are streams. A tuning word is offered with `in_valid` and is taken on any clock edge where `in_ready` is also high. Each word that is taken advances the modulator by exactly one step and places one code in the output register. The output register holds that code, with `out_valid` high, until the consumer raises `out_ready`. While a code waits, `in_ready` is low and the modulator does not move. The input word can differ on every step.

Top module: `dsm3_nine_level`

## Requirements
- R1: Reset clears all three integrators to zero and drops `out_valid`. The first code produced after reset is therefore 0.
- R2: Every code presented with `out_valid` high lies in the range 0 to 8. It is carried as an unsigned 4-bit value.
- R3: The code produced by a step is computed from the third integrator's value before that step. Call that value v. The code is (16·v + 2·v), taken with 32-bit wrap and arithmetically shifted right by 13. Results below 0 give 0, and results above 8 give 8.
- R4: On a step, the third integrator gains (second integrator >>> 5) − 512·code − 256·code. The second integrator value used is the one from before the step.
- R5: On a step, the second integrator gains (first integrator >>> 5) − 16384·code. The first integrator value used is the one from before the step.
- R6: On a step, the first integrator gains the input word, zero-extended, minus 131072·code.
- R7: All three integrators are 32-bit two's-complement registers whose sums wrap on overflow.
- R8: A step occurs only on a clock edge where both `in_valid` and `in_ready` are high. On any other edge the integrators keep their values.
- R9: `in_ready` is high exactly when the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, `out_code` stays constant and `in_ready` is low.
- R10: When a code is drained and no new step is taken on the same edge, `out_valid` falls on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A tuning word is offered |
| in_ready | output | 1 | The block will take the offered word on this edge |
| in_word | input | 20 | Unsigned tuning word |
| out_valid | output | 1 | `out_code` holds a code not yet taken |
| out_ready | input | 1 | The consumer takes the code on this edge |
| out_code | output | 4 | Quantised code, 0 to 8 |

## Verification
The bench sweeps the input over zero, one, the full-scale word, mid-scale and a fast-changing pattern. It compares every code against an arithmetic model. A wrong feedback weight, an inter-stage shift that is logical instead of arithmetic, or a quantiser that reads the updated third integrator would show up as a drifting sequence after a few steps. Full-scale input pushes the quantiser into its upper clamp, and zero input lets it settle below zero. A missing clamp would emit codes such as 9 or large negative patterns. Stalls with `out_ready` low, combined with a changing offered word, show whether the state advances, or the held code changes, while the consumer is not listening. A mid-run reset checks that all integrators really clear.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int ACC_W       = 32;
  localparam int IN_W        = 20;
  localparam int CODE_W      = 4;
  localparam int MAX_CODE    = 8;
  localparam int N_STAGES    = 3;
  localparam int TAP_SHIFT   = 5;
  localparam int QUANT_SHIFT = 13;
  localparam int QGAIN_HI    = 4;
  localparam int QGAIN_LO    = 1;
endpackage

// File: rtl/dsm_quant.sv
module dsm_quant #(
  parameter int ACC_W       = dsm_pkg::ACC_W,
  parameter int CODE_W      = dsm_pkg::CODE_W,
  parameter int QUANT_SHIFT = dsm_pkg::QUANT_SHIFT,
  parameter int QGAIN_HI    = dsm_pkg::QGAIN_HI,
  parameter int QGAIN_LO    = dsm_pkg::QGAIN_LO,
  parameter int MAX_CODE    = dsm_pkg::MAX_CODE
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic [CODE_W-1:0]       code
);
  localparam logic signed [ACC_W-1:0] TOP_V = ACC_W'(MAX_CODE);

  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    // gain of 18 built from two shifts, wrapping at ACC_W bits
    scaled  = (acc <<< QGAIN_HI) + (acc <<< QGAIN_LO);
    shifted = scaled >>> QUANT_SHIFT;
    if (shifted < 0)
      code = '0;
    else if (shifted > TOP_V)
      code = CODE_W'(MAX_CODE);
    else
      code = shifted[CODE_W-1:0];
  end
endmodule

// File: rtl/dsm_feedback.sv
module dsm_feedback #(
  parameter int ACC_W  = dsm_pkg::ACC_W,
  parameter int CODE_W = dsm_pkg::CODE_W,
  parameter int STAGE  = 0
) (
  input  logic [CODE_W-1:0]       code,
  output logic signed [ACC_W-1:0] fb
);
  logic signed [ACC_W-1:0] wide;
  assign wide = $signed({{(ACC_W-CODE_W){1'b0}}, code});

  generate
    if (STAGE == 0) begin : g_first
      assign fb = wide <<< 17;
    end else if (STAGE == 1) begin : g_second
      assign fb = wide <<< 14;
    end else begin : g_third
      assign fb = (wide <<< 9) + (wide <<< 8);
    end
  endgenerate
endmodule

// File: rtl/dsm_integ.sv
module dsm_integ #(
  parameter int ACC_W     = dsm_pkg::ACC_W,
  parameter int DRV_SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic signed [ACC_W-1:0] drive,
  input  logic signed [ACC_W-1:0] fb,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] nxt;
  assign nxt = acc + (drive >>> DRV_SHIFT) - fb;

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (step)
      acc <= nxt;
  end
endmodule

// File: rtl/dsm_outreg.sv
module dsm_outreg #(
  parameter int CODE_W = dsm_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              step,
  input  logic [CODE_W-1:0] code_d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code
);
  assign in_ready = !out_valid || out_ready;
  assign step     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (step) begin
      out_valid <= 1'b1;
      out_code  <= code_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dsm3_nine_level.sv
module dsm3_nine_level #(
  parameter int IN_W      = dsm_pkg::IN_W,
  parameter int ACC_W     = dsm_pkg::ACC_W,
  parameter int CODE_W    = dsm_pkg::CODE_W,
  parameter int TAP_SHIFT = dsm_pkg::TAP_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code
);
  localparam int NS = dsm_pkg::N_STAGES;

  logic                    step;
  logic [CODE_W-1:0]       code_d;
  logic signed [ACC_W-1:0] acc   [NS];
  logic signed [ACC_W-1:0] drive [NS];
  logic signed [ACC_W-1:0] fb    [NS];

  // code from the pre-step value of the last integrator
  dsm_quant #(.ACC_W(ACC_W), .CODE_W(CODE_W)) quant_i (
    .acc (acc[NS-1]),
    .code(code_d)
  );

  generate
    for (genvar s = 0; s < NS; s++) begin : g_stage
      if (s == 0) begin : g_in
        assign drive[s] = $signed({{(ACC_W-IN_W){1'b0}}, in_word});
      end else begin : g_chain
        assign drive[s] = acc[s-1];
      end

      dsm_feedback #(.ACC_W(ACC_W), .CODE_W(CODE_W), .STAGE(s)) fb_i (
        .code(code_d),
        .fb  (fb[s])
      );

      dsm_integ #(.ACC_W(ACC_W), .DRV_SHIFT(s == 0 ? 0 : TAP_SHIFT)) integ_i (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .drive(drive[s]),
        .fb   (fb[s]),
        .acc  (acc[s])
      );
    end
  endgenerate

  dsm_outreg #(.CODE_W(CODE_W)) outreg_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .step     (step),
    .code_d   (code_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_code (out_code)
  );
endmodule

// File: rtl/dsm3_nine_level_chk.sv
module dsm3_nine_level_chk #(
  parameter int CODE_W = dsm_pkg::CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code
);
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code <= CODE_W'(dsm_pkg::MAX_CODE)));

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_drain_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !in_valid) |=> !out_valid);

  assert_accept_fills_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind dsm3_nine_level dsm3_nine_level_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
);

// File: tb/dsm3_nine_level_tb_top.sv
module dsm3_nine_level_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m1 = 0, m2 = 0, m3 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm3_nine_level dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code)
  );

  // R3: code from the old third integrator, gain 18, >>>13, clamp 0..8
  function automatic int quant(int v);
    int p = (v <<< 4) + (v <<< 1);
    int s = p >>> 13;
    if (s < 0) return 0;
    if (s > 8) return 8;
    return s;
  endfunction

  // R4 R5 R6: one step of the model; int arithmetic wraps at 32 bits (R7)
  function automatic int model_step(logic [19:0] w);
    int q = quant(m3);
    m3 = m3 + (m2 >>> 5) - (q <<< 9) - (q <<< 8);
    m2 = m2 + (m1 >>> 5) - (q <<< 14);
    m1 = m1 + int'({12'b0, w}) - (q <<< 17);
    return q;
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic step_check(string tag, logic [19:0] w);
    int q;
    @(negedge clk);
    check({tag, " in_ready"}, int'(in_ready), 1);
    in_valid = 1'b1;
    in_word  = w;
    q = model_step(w);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, int'(out_valid), 1);
    check({tag, " code"}, int'(out_code), q);
    check("R2 range", int'(out_code <= 4'd8), 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m1 = 0; m2 = 0; m3 = 0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
  endtask

  initial begin
    do_reset();
    step_check("R1 first code", 20'h12345);

    for (int i = 0; i < 200; i++) step_check("R3 zero input", 20'h00000);
    for (int i = 0; i < 200; i++) step_check("R6 input one", 20'h00001);
    for (int i = 0; i < 300; i++) step_check("R3 full scale", 20'hFFFFF);
    for (int i = 0; i < 300; i++) step_check("R5 mid scale", 20'h80000);
    for (int i = 0; i < 300; i++) step_check("R4 odd word", 20'h2B7C1);
    for (int i = 0; i < 400; i++)
      step_check("R7 varying word", 20'((i * 7919 + 12345) & 20'hFFFFF));
    for (int i = 0; i < 200; i++) step_check("R4 ramp", 20'(i * 5243));

    // R9 stall: code held, in_ready low, state frozen while word changes
    begin
      int q;
      logic [3:0] held;
      @(negedge clk);
      out_ready = 1'b0;
      in_valid  = 1'b1;
      in_word   = 20'hC0DE5;
      q = model_step(20'hC0DE5);
      @(negedge clk);
      check("R9 stalled code", int'(out_code), q);
      held = out_code;
      for (int k = 0; k < 5; k++) begin
        in_word = 20'(k * 99991);
        @(negedge clk);
        check("R9 in_ready low", int'(in_ready), 0);
        check("R9 code stable", int'(out_code), int'(held));
        check("R8 valid held", int'(out_valid), 1);
      end
      in_valid  = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      check("R10 drained", int'(out_valid), 0);
    end
    // R8 continuity: model advanced only on the accepted step
    for (int i = 0; i < 50; i++) step_check("R8 after stall", 20'h3F00F);

    // R1 mid-run reset
    do_reset();
    for (int i = 0; i < 100; i++) step_check("R1 after reset", 20'hA5A5A);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule